// File: doc/BRIEF.md
# TDM Serial Frame Timer

This block produces the bit, channel and frame timing for a 2.048 Mb/s time-division serial backplane. It also converts eight serial receive streams to bytes and eight transmit bytes back to serial bits. It runs on one clock at twice the master serial clock, 8.192 MHz for a 4.096 MHz master. Each clock cycle is therefore one half-period of the master clock, and a bit cell is four cycles (quarters 0 to 3). A frame is 32 channels of 8 bits, which is 1024 cycles.

The 8 kHz frame pulse can follow either of two backplane conventions. One uses a short active-low pulse and the other a short active-high pulse. The block tells them apart by measuring how long the line stays away from its idle level. It locks once two pulses of the same polarity arrive in a row. For the active-low convention, bit boundaries sit on master falling edges and sampling on rising edges. For the active-high convention these move by half a master period: boundaries sit on rising edges and sampling on falling edges. In both cases sampling falls three quarters of the way into the cell.

The switch core receives one byte per stream at the end of every channel, tagged with the channel number. It supplies the bytes for the next channel at the same boundary. A missing frame pulse raises a loss-of-framing flag.

Top module: `tdm_frame_timer`

## Requirements
- R1: A frame pulse is a run of one level on `fp_i` that lasts 1 to PULSE_MAX (8) cycles before the line returns to its previous level. A low run marks the active-low convention (`conv_gci_o`=0) and a high run marks the active-high convention (`conv_gci_o`=1). Longer runs are not pulses.
- R2: `locked_o` rises, and `conv_gci_o` takes the new polarity, on the second of two consecutive pulses of equal polarity. A pulse of the other polarity drops lock and restarts matching.
- R3: Active-low convention: the first cycle of channel 0, bit 0, quarter 0 directly follows the clock edge that sees the pulse end. Active-high convention: that cycle comes one cycle later.
- R4: `chan_o` and `bit_idx_o` give the current channel (0 to 31) and the bit (0 = first sent). The counters wrap every 1024 cycles. `bit_stb_o` is high in quarter 0 and `smp_stb_o` in quarter 2, both only while locked.
- R5: Each receive stream is sampled at the edge that ends quarter 2, most significant bit first.
- R6: `rx_valid_o` is high for exactly the one cycle that follows the eighth sample of each channel, and only while locked. In that cycle `rx_chan_o` holds the channel and `rx_data_o[8s+7:8s]` holds the byte of stream s.
- R7: `tx_load_o` is high in that same cycle, with `tx_load_chan_o` = channel+1 mod 32. At the end of that cycle `tx_data_i[8s+7:8s]` is taken in. `tx_o[s]` then sends it most significant bit first and changes only at bit boundaries.
- R8: If FRAME_CLKS+1 (1025) edges pass after the last pulse with no new one, `frame_lost_o` rises and `locked_o` falls. The flag clears when lock is regained.
- R9: Reset is synchronous and active high. During reset `locked_o`, `frame_lost_o`, `rx_valid_o`, `bit_stb_o`, `tx_load_o` and `tx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the master serial rate |
| rst | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | Frame pulse, either polarity |
| rx_i | input | 8 | Serial receive streams |
| tx_data_i | input | 64 | Next-channel transmit bytes, stream s in bits 8s+7:8s |
| tx_o | output | 8 | Serial transmit streams |
| locked_o | output | 1 | Frame timing locked |
| conv_gci_o | output | 1 | Detected convention, 1 = active-high pulse |
| frame_lost_o | output | 1 | Frame pulse missing |
| bit_stb_o | output | 1 | Bit-boundary quarter |
| smp_stb_o | output | 1 | Sampling quarter |
| chan_o | output | 5 | Current channel |
| bit_idx_o | output | 3 | Current bit within channel |
| rx_valid_o | output | 1 | Received bytes valid |
| rx_chan_o | output | 5 | Channel of received bytes |
| rx_data_o | output | 64 | Received bytes, stream s in bits 8s+7:8s |
| tx_load_o | output | 1 | Transmit bytes taken at end of cycle |
| tx_load_chan_o | output | 5 | Channel the taken bytes belong to |

## Verification
Two framed runs are made, one with active-low pulses and one with active-high pulses, each starting at a random phase and carrying random bytes on every stream. Every byte, bit and strobe is compared against the position predicted from the pulse. The half-cycle shift between the two conventions appears as a one-cycle difference in the channel-0 start, so a timing offset applied to the wrong convention is caught. Each run then withholds the pulse to expose the loss-of-framing window. A directed sequence follows: over-long runs that must not count as pulses, then a pulse of one polarity followed by one of the other, which must not lock. These separate width qualification from polarity matching.

// File: rtl/tdmt_pkg.sv
package tdmt_pkg;

    localparam int CHAN_N     = 32;
    localparam int BIT_N      = 8;
    localparam int QTR_N      = 4;
    localparam int FRAME_CLKS = CHAN_N * BIT_N * QTR_N;
    localparam int CHAN_W     = $clog2(CHAN_N);
    localparam int BIT_W      = $clog2(BIT_N);
    localparam int QTR_W      = $clog2(QTR_N);
    localparam int POS_W      = CHAN_W + BIT_W + QTR_W;

    localparam logic [QTR_W-1:0] QTR_BOUND  = QTR_W'(0);
    localparam logic [QTR_W-1:0] QTR_SAMPLE = QTR_W'(2);
    localparam logic [QTR_W-1:0] QTR_LAST   = QTR_W'(QTR_N - 1);
    localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(BIT_N - 1);

    typedef enum logic {
        CONV_LOW  = 1'b0,
        CONV_HIGH = 1'b1
    } fp_conv_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [BIT_W-1:0]  bitn;
        logic [QTR_W-1:0]  qtr;
    } slot_pos_t;

    // Position loaded on the edge that sees a pulse end: the active-high
    // convention starts half a master period later.
    function automatic logic [POS_W-1:0] resync_pos(fp_conv_e conv);
        return (conv == CONV_LOW) ? '0 : '1;
    endfunction

endpackage

// File: rtl/tdmt_fp_detect.sv
module tdmt_fp_detect
    import tdmt_pkg::*;
#(
    parameter int PULSE_MAX = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     fp_i,
    output logic     pulse_o,
    output fp_conv_e pol_o,
    output logic     locked_o,
    output fp_conv_e conv_o,
    output logic     lost_o
);
    localparam int RUN_W = $clog2(PULSE_MAX + 2);
    localparam int GAP_W = $clog2(FRAME_CLKS + 2);
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(PULSE_MAX);
    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(FRAME_CLKS);

    logic             fp_q;
    logic [RUN_W-1:0] run_q;
    logic [GAP_W-1:0] gap_q;
    logic             cand_v_q;
    fp_conv_e         cand_q;
    logic             locked_q;
    fp_conv_e         conv_q;
    logic             lost_q;
    logic             level_chg;
    logic             expire;

    assign level_chg = (fp_i != fp_q);
    assign pulse_o   = level_chg && (run_q <= RUN_LIM);
    assign pol_o     = fp_q ? CONV_HIGH : CONV_LOW;
    assign expire    = !pulse_o && (gap_q == GAP_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            fp_q     <= fp_i;
            run_q    <= RUN_LIM + 1'b1;
            gap_q    <= '0;
            cand_v_q <= 1'b0;
            cand_q   <= CONV_LOW;
            locked_q <= 1'b0;
            conv_q   <= CONV_LOW;
            lost_q   <= 1'b0;
        end else begin
            fp_q <= fp_i;
            if (level_chg)
                run_q <= RUN_W'(1);
            else if (run_q <= RUN_LIM)
                run_q <= run_q + 1'b1;

            if (pulse_o)
                gap_q <= '0;
            else if (gap_q <= GAP_LIM)
                gap_q <= gap_q + 1'b1;

            if (pulse_o) begin
                if (cand_v_q && (cand_q == pol_o)) begin
                    locked_q <= 1'b1;
                    conv_q   <= pol_o;
                    lost_q   <= 1'b0;
                end else begin
                    locked_q <= 1'b0;
                end
                cand_v_q <= 1'b1;
                cand_q   <= pol_o;
            end else if (expire) begin
                locked_q <= 1'b0;
                lost_q   <= 1'b1;
                cand_v_q <= 1'b0;
            end
        end
    end

    assign locked_o = locked_q;
    assign conv_o   = conv_q;
    assign lost_o   = lost_q;

    assert_lost_unlocked_R8: assert property (@(posedge clk) disable iff (rst)
        lost_q |-> !locked_q);

    assert_lock_after_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> $past(pulse_o));

endmodule

// File: rtl/tdmt_slot_counter.sv
module tdmt_slot_counter
    import tdmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      resync_i,
    input  fp_conv_e  pol_i,
    output slot_pos_t pos_o
);
    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (resync_i)
            pos_q <= resync_pos(pol_i);
        else
            pos_q <= pos_q + 1'b1;
    end

    assign pos_o = slot_pos_t'(pos_q);

    assert_resync_low_R3: assert property (@(posedge clk) disable iff (rst)
        (resync_i && pol_i == CONV_LOW) |=> (pos_q == '0));

    assert_resync_high_R3: assert property (@(posedge clk) disable iff (rst)
        (resync_i && pol_i == CONV_HIGH) |=> (pos_q == '1));

endmodule

// File: rtl/tdmt_lane.sv
module tdmt_lane
    import tdmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_i,
    input  logic             smp_en_i,
    input  logic             cap_en_i,
    input  logic             shift_en_i,
    input  logic             load_en_i,
    input  logic [BIT_N-1:0] tx_byte_i,
    output logic [BIT_N-1:0] rx_byte_o,
    output logic             tx_o
);
    logic [BIT_N-1:0] rx_sh_q;
    logic [BIT_N-1:0] rx_hold_q;
    logic [BIT_N-1:0] tx_sh_q;
    logic [BIT_N-1:0] rx_next;

    assign rx_next = {rx_sh_q[BIT_N-2:0], rx_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh_q   <= '0;
            rx_hold_q <= '0;
            tx_sh_q   <= '0;
        end else begin
            if (smp_en_i)
                rx_sh_q <= rx_next;
            if (cap_en_i)
                rx_hold_q <= rx_next;
            if (load_en_i)
                tx_sh_q <= tx_byte_i;
            else if (shift_en_i)
                tx_sh_q <= {tx_sh_q[BIT_N-2:0], 1'b0};
        end
    end

    assign rx_byte_o = rx_hold_q;
    assign tx_o      = tx_sh_q[BIT_N-1];

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdmt_pkg::*;
#(
    parameter int NSTREAM   = 8,
    parameter int PULSE_MAX = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fp_i,
    input  logic [NSTREAM-1:0]         rx_i,
    input  logic [NSTREAM*BIT_N-1:0]   tx_data_i,
    output logic [NSTREAM-1:0]         tx_o,
    output logic                       locked_o,
    output logic                       conv_gci_o,
    output logic                       frame_lost_o,
    output logic                       bit_stb_o,
    output logic                       smp_stb_o,
    output logic [CHAN_W-1:0]          chan_o,
    output logic [BIT_W-1:0]           bit_idx_o,
    output logic                       rx_valid_o,
    output logic [CHAN_W-1:0]          rx_chan_o,
    output logic [NSTREAM*BIT_N-1:0]   rx_data_o,
    output logic                       tx_load_o,
    output logic [CHAN_W-1:0]          tx_load_chan_o
);
    logic      pulse;
    fp_conv_e  pulse_pol;
    logic      locked;
    fp_conv_e  conv;
    logic      lost;
    slot_pos_t pos;
    logic      in_sample_q;
    logic      in_last_q;
    logic      last_bit;
    logic      rx_valid_q;
    logic [CHAN_W-1:0] rx_chan_q;

    tdmt_fp_detect #(.PULSE_MAX(PULSE_MAX)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .fp_i     (fp_i),
        .pulse_o  (pulse),
        .pol_o    (pulse_pol),
        .locked_o (locked),
        .conv_o   (conv),
        .lost_o   (lost)
    );

    tdmt_slot_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .resync_i (pulse),
        .pol_i    (pulse_pol),
        .pos_o    (pos)
    );

    assign in_sample_q = (pos.qtr == QTR_SAMPLE);
    assign in_last_q   = (pos.qtr == QTR_LAST);
    assign last_bit    = (pos.bitn == BIT_LAST);

    for (genvar s = 0; s < NSTREAM; s++) begin : g_lane
        tdmt_lane u_lane (
            .clk        (clk),
            .rst        (rst),
            .rx_i       (rx_i[s]),
            .smp_en_i   (in_sample_q),
            .cap_en_i   (in_sample_q && last_bit),
            .shift_en_i (in_last_q && !last_bit),
            .load_en_i  (in_last_q && last_bit),
            .tx_byte_i  (tx_data_i[s*BIT_N +: BIT_N]),
            .rx_byte_o  (rx_data_o[s*BIT_N +: BIT_N]),
            .tx_o       (tx_o[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid_q <= 1'b0;
            rx_chan_q  <= '0;
        end else begin
            rx_valid_q <= locked && in_sample_q && last_bit;
            if (in_sample_q && last_bit)
                rx_chan_q <= pos.chan;
        end
    end

    assign locked_o       = locked;
    assign conv_gci_o     = (conv == CONV_HIGH);
    assign frame_lost_o   = lost;
    assign bit_stb_o      = locked && (pos.qtr == QTR_BOUND);
    assign smp_stb_o      = locked && in_sample_q;
    assign chan_o         = pos.chan;
    assign bit_idx_o      = pos.bitn;
    assign rx_valid_o     = rx_valid_q;
    assign rx_chan_o      = rx_chan_q;
    assign tx_load_o      = locked && in_last_q && last_bit;
    assign tx_load_chan_o = pos.chan + 1'b1;

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid_q |=> !rx_valid_q);

    assert_tx_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        (pos.qtr != QTR_LAST) |=> $stable(tx_o));

endmodule

// File: tb/tdm_frame_timer_bench.sv
module tdm_frame_timer_bench;
    localparam int NS = 8;
    localparam int FR = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fp  = 1'b1;
    logic [NS-1:0] rx  = '0;
    logic [NS*8-1:0] txd = '0;
    logic [NS-1:0] tx_o;
    logic          locked, conv_gci, lost, bit_stb, smp_stb, rx_valid, tx_load;
    logic [4:0]    chan, rx_chan, tx_load_chan;
    logic [2:0]    bit_idx;
    logic [NS*8-1:0] rx_data;

    int  n = 0;
    int  f0 = 0;
    int  np = 0;
    int  pol_g = 0;
    int  tlast = 0;
    bit  pulses_on = 1'b0;
    int  vecs = 0;
    int  errs = 0;
    bit  done = 1'b0;
    logic [7:0] rxpat [4][NS][32];
    logic [7:0] txpat [4][NS][32];

    tdm_frame_timer #(.NSTREAM(NS), .PULSE_MAX(8)) u_tdm_frame_timer (
        .clk(clk), .rst(rst), .fp_i(fp), .rx_i(rx), .tx_data_i(txd),
        .tx_o(tx_o), .locked_o(locked), .conv_gci_o(conv_gci),
        .frame_lost_o(lost), .bit_stb_o(bit_stb), .smp_stb_o(smp_stb),
        .chan_o(chan), .bit_idx_o(bit_idx), .rx_valid_o(rx_valid),
        .rx_chan_o(rx_chan), .rx_data_o(rx_data), .tx_load_o(tx_load),
        .tx_load_chan_o(tx_load_chan)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s edge %0d: actual %h expected %h", req, n, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        n = n + 1;
        @(negedge clk);
    endtask

    function automatic logic fp_for(int m);
        int  r;
        logic act;
        act = (pol_g != 0);
        r = m - f0 + ((pol_g != 0) ? 5 : 4);
        if (!pulses_on || r < 0 || (r / FR) >= np) return !act;
        return ((r % FR) < 4) ? act : !act;
    endfunction

    task automatic drive(input int m);
        int p, o, c, b;
        fp = fp_for(m);
        p = m - 1 - f0;
        for (int s = 0; s < NS; s++) begin
            if (p >= 0) begin
                o = p % FR; c = o >> 5; b = (o >> 2) & 7;
                rx[s] = rxpat[(p / FR) % 4][s][c][7 - b];
            end else begin
                rx[s] = 1'($urandom % 2);
            end
        end
        p = m - f0;
        for (int s = 0; s < NS; s++)
            txd[s*8 +: 8] = (p >= 0) ? txpat[(p / FR) % 4][s][(p % FR) >> 5] : 8'($urandom);
    endtask

    task automatic check_edge(input int m);
        int p, o, frm, c, b, q;
        logic [NS-1:0]   etx;
        logic [NS*8-1:0] erx;
        p = m - f0;
        if (p >= FR && m <= tlast + 1000) begin
            o = p % FR; frm = (p / FR) % 4; c = o >> 5; b = (o >> 2) & 7; q = o & 3;
            chk("R4 strobes/chan/bit", {54'd0, bit_stb, smp_stb, chan, bit_idx},
                {54'd0, q == 0, q == 2, 5'(c), 3'(b)});
            for (int s = 0; s < NS; s++) etx[s] = txpat[frm][s][c][7 - b];
            chk("R7 tx bits", 64'(tx_o), 64'(etx));
            chk("R6 rx_valid", 64'(rx_valid), 64'((o % 32) == 31));
            chk("R7 tx_load", {58'd0, tx_load, tx_load_chan},
                {58'd0, (o % 32) == 31, 5'(c + 1)});
            if ((o % 32) == 31) begin
                for (int s = 0; s < NS; s++) erx[s*8 +: 8] = rxpat[frm][s][c];
                chk("R5 rx bytes", 64'(rx_data), 64'(erx));
                chk("R6 rx_chan", 64'(rx_chan), 64'(c));
            end
        end
        if (p >= 0 && p < FR - 1)
            chk("R6 gated before lock", {61'd0, rx_valid, bit_stb, tx_load}, 64'd0);
        if (m == f0)
            chk("R3 channel 0 start", {56'd0, chan, bit_idx}, 64'd0);
        if (pol_g != 0 && m == f0 - 1)
            chk("R3 half-period shift", {56'd0, chan, bit_idx}, {56'd0, 5'd31, 3'd7});
        if (m == f0 + 1100)
            chk("R2 lock and polarity", {62'd0, locked, conv_gci}, {62'd0, 1'b1, pol_g != 0});
        if (m == tlast + 1020)
            chk("R8 still framed", {62'd0, lost, locked}, 64'b01);
        if (m == tlast + 1030)
            chk("R8 framing lost", {62'd0, lost, locked}, 64'b10);
    endtask

    task automatic run_phase(input int pol, input int pulses, input int off);
        pol_g = pol; np = pulses; pulses_on = 1'b0;
        fp = (pol != 0) ? 1'b0 : 1'b1;
        rx = '0; txd = '0; rst = 1'b1;
        repeat (4) step();
        chk("R9 reset state", {56'd0, locked, lost, rx_valid, bit_stb, tx_load, 3'd0},
            64'd0);
        chk("R9 reset tx", 64'(tx_o), 64'd0);
        rst = 1'b0;
        f0 = n + 40 + off;
        tlast = f0 + (np - 1) * FR - ((pol != 0) ? 1 : 0);
        pulses_on = 1'b1;
        drive(n + 1);
        while (n < tlast + 1035) begin
            step();
            check_edge(n);
            drive(n + 1);
        end
        pulses_on = 1'b0;
    endtask

    task automatic hold(input logic lvl, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            fp = lvl;
            step();
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int f = 0; f < 4; f++)
            for (int s = 0; s < NS; s++)
                for (int c = 0; c < 32; c++) begin
                    rxpat[f][s][c] = 8'($urandom);
                    txpat[f][s][c] = 8'($urandom);
                end
        rxpat[0][0][0] = 8'h80;
        rxpat[1][0][0] = 8'h01;
        txpat[1][1][0] = 8'hFF;
        txpat[1][2][0] = 8'h00;

        run_phase(0, 4, int'($urandom % 100));
        run_phase(1, 4, int'($urandom % 100));

        // Directed: width qualification and polarity matching
        pol_g = 0; pulses_on = 1'b0;
        fp = 1'b1; rst = 1'b1;
        repeat (4) step();
        rst = 1'b0;
        hold(1'b0, 20); hold(1'b1, 400);
        hold(1'b0, 20); hold(1'b1, 400);
        chk("R1 long runs not pulses", {62'd0, locked, lost}, 64'd0);
        hold(1'b0, 4); hold(1'b1, 300);
        hold(1'b0, 300); hold(1'b1, 4);
        hold(1'b0, 10);
        chk("R2 mixed polarity no lock", 64'(locked), 64'd0);
        hold(1'b0, 1010); hold(1'b1, 4);
        hold(1'b0, 10);
        chk("R1 high pulse gives GCI lock", {62'd0, locked, conv_gci}, 64'b11);
        chk("R8 flag clear while locked", 64'(lost), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule